// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block paces the temperature conversions of a digital thermometer and keeps the latest result. A behavioural converter stub presents a 12-bit two's-complement sample at 1/16 °C per step. At the end of each conversion window the sequencer captures that sample. It clears the low bits that the selected resolution does not resolve and publishes the value left-justified in a 16-bit word, with a one-cycle completion pulse.

An 8-bit configuration byte controls operation. Software can choose one of four resolutions, and each finer step doubles the conversion window. It can let conversions run back to back, or request a stop that takes effect only when the conversion in flight has finished. While stopped, it can trigger a single conversion, after which the block stops again. The fault-count, polarity and mode fields are kept in the byte for a neighbouring alert block and have no effect here.

Top module: `temp_conv_seq`

## Requirements
- R1: After reset the temperature word is 0, the configuration reads 0x00, and conversions run continuously at the coarsest resolution. The first completion pulse comes BASE_CYCLES clock cycles after reset is released.
- R2: The configuration byte holds a start-single-conversion request in bit 7, the resolution code in bits 6:5, the fault count in bits 4:3, polarity in bit 2, mode in bit 1 and the stop request in bit 0. Bits 6:0 read back as written, and bit 7 always reads 0.
- R3: With resolution code r (0 to 3, meaning 9 to 12 bits), a conversion lasts BASE_CYCLES << r cycles, so back-to-back completion pulses are that far apart. The code in effect when a conversion starts governs that conversion.
- R4: The result is the sample present at completion with its lowest 3 - r bits forced to 0, placed in bits 15:4 of the word, with bits 3:0 at 0.
- R5: The completion pulse is high for exactly one cycle, in the cycle the new word first appears. The word holds its value at all other times.
- R6: When the stop bit is set during a conversion, that conversion completes and delivers its result. The block then goes idle: the active flag drops and no further pulses occur.
- R7: While idle, a write with bits 7 and 0 both set runs exactly one conversion at the resolution written, then returns to idle.
- R8: A single-conversion request written while a conversion is running is ignored; it neither restarts nor lengthens the conversion.
- R9: While idle, a write with the stop bit clear resumes continuous conversions, starting on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration byte to write |
| adcSample | input | SAMPLE_W | Sample from the converter stub |
| cfgRdData | output | 8 | Configuration readback, bit 7 always 0 |
| convActive | output | 1 | High while a conversion is in progress |
| convDone | output | 1 | One-cycle completion pulse |
| tempWord | output | SAMPLE_W+4 | Left-justified masked result |

## Verification
The bench pairs random samples with random resolution codes and aims at four hazards.

- **Resolution change mid-conversion.** A design that took the new code immediately would cut or stretch the conversion already running.
- **Masking by resolution.** A design that masked with the wrong code would leave stray low bits in the word, or clear valid ones.
- **Late stop.** Setting the stop bit in the middle of a conversion catches a design that aborts early and loses the result, or one that starts one more conversion.
- **Single-conversion edges.** A request while running must be ignored, and a request while idle must give exactly one pulse. Either error would show up as a restarted window or as repeated pulses after the single conversion.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {ST_IDLE, ST_CONV} tcsStateT;

  typedef struct packed {
    logic       capture;
    logic [1:0] res;
  } tcsStrobeT;
endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
#(
  parameter int BASE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  output logic       convActive,
  output tcsStrobeT  strobe
);
  localparam int CNT_W = $clog2(BASE_CYCLES * 8 + 1);

  tcsStateT         state;
  logic [6:0]       cfgReg;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       convRes;

  wire [1:0] cfgRes = cfgReg[6:5];
  wire       cfgSd  = cfgReg[0];
  wire [1:0] wrRes  = cfgWrData[6:5];
  wire       wrSd   = cfgWrData[0];
  wire       wrOs   = cfgWrData[7];
  wire       lastCycle = (state == ST_CONV) && (cnt == '0);

  function automatic logic [CNT_W-1:0] windowLoad(input logic [1:0] r);
    logic [CNT_W-1:0] span;
    span = CNT_W'(BASE_CYCLES) << r;
    return span - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData[6:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CONV;
      cnt     <= windowLoad(2'd0);
      convRes <= 2'd0;
    end else begin
      unique case (state)
        ST_CONV: begin
          if (lastCycle) begin
            if (cfgSd) begin
              state <= ST_IDLE;
            end else begin
              cnt     <= windowLoad(cfgRes);
              convRes <= cfgRes;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_IDLE: begin
          if (cfgWrEn && (wrOs || !wrSd)) begin
            state   <= ST_CONV;
            cnt     <= windowLoad(wrRes);
            convRes <= wrRes;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cfgRdData      = {1'b0, cfgReg};
  assign convActive     = (state == ST_CONV);
  assign strobe.capture = lastCycle;
  assign strobe.res     = convRes;
endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tcsStrobeT             strobe,
  input  logic [SAMPLE_W-1:0]   adcSample,
  output logic                  convDone,
  output logic [SAMPLE_W+3:0]   tempWord
);
  localparam int WORD_W = SAMPLE_W + 4;

  logic [SAMPLE_W-1:0] keepMask;
  logic [SAMPLE_W-1:0] maskedSample;

  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_mask
    if (b >= 3) begin : g_always
      assign keepMask[b] = 1'b1;
    end else begin : g_res
      assign keepMask[b] = (32'(strobe.res) >= (3 - b));
    end
  end

  assign maskedSample = adcSample & keepMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempWord <= '0;
      convDone <= 1'b0;
    end else begin
      convDone <= strobe.capture;
      if (strobe.capture) begin
        tempWord <= WORD_W'({maskedSample, 4'b0000});
      end
    end
  end
endmodule

// File: rtl/temp_conv_seq.sv
module temp_conv_seq
  import tcs_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int SAMPLE_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [7:0]          cfgWrData,
  input  logic [SAMPLE_W-1:0] adcSample,
  output logic [7:0]          cfgRdData,
  output logic                convActive,
  output logic                convDone,
  output logic [SAMPLE_W+3:0] tempWord
);
  tcsStrobeT strobe;

  tcs_ctrl #(.BASE_CYCLES(BASE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .convActive(convActive), .strobe(strobe)
  );

  tcs_datapath #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcSample(adcSample),
    .convDone(convDone), .tempWord(tempWord)
  );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [7:0]          cfgRdData,
  input logic                convActive,
  input logic                convDone,
  input logic [SAMPLE_W+3:0] tempWord
);
  assert_os_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[7] == 1'b0);

  assert_low_nibble_R4: assert property (@(posedge clk) disable iff (!rstN)
    tempWord[3:0] == 4'h0);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> $stable(tempWord));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !convActive |=> !convDone);

  assert_stop_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convDone) && $past(cfgRdData[0])) |-> !convActive);

  assert_run_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convDone) && !$past(cfgRdData[0])) |-> convActive);
endmodule

bind temp_conv_seq tcs_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .convActive(convActive),
  .convDone(convDone), .tempWord(tempWord)
);

// File: tb/temp_conv_seq_tb.sv
`timescale 1ns/1ps
module temp_conv_seq_tb_top;
  localparam int BASE = 16;
  localparam int SW   = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [7:0]    cfgWrData = '0;
  logic [SW-1:0] adcSample = '0;
  logic [7:0]    cfgRdData;
  logic          convActive;
  logic          convDone;
  logic [SW+3:0] tempWord;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  temp_conv_seq #(.BASE_CYCLES(BASE), .SAMPLE_W(SW)) dut_i (.*);

  function automatic int periodOf(input int r);
    return BASE << r;
  endfunction

  function automatic logic [SW+3:0] expWord(input logic [SW-1:0] s, input int r);
    logic [SW-1:0] m;
    m = {SW{1'b1}} << (3 - r);
    return {s & m, 4'h0};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Counts negedges until convDone is seen; returns -1 on timeout.
  task automatic waitDone(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (convDone) begin n = i; break; end
    end
  endtask

  // Samples for n cycles and reports whether any pulse was seen.
  task automatic quietFor(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (convDone) seen = 1'b1;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int n;
    bit seen;
    logic [SW+3:0] held;
    void'($urandom(32'h5EED_0C2A));
    adcSample = 12'hA5F;
    #1;
    check(tempWord == 0, "R1 word at reset", tempWord, 0);
    check(cfgRdData == 0, "R1 cfg at reset", cfgRdData, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    waitDone(4 * BASE, n);
    check(n == BASE, "R1 first pulse", n, BASE);
    check(tempWord == expWord(12'hA5F, 0), "R4 9-bit mask", tempWord, expWord(12'hA5F, 0));

    // Random resolution/sample trials; write mid-window, measure the window after.
    for (int t = 0; t < 10; t++) begin
      int r;
      logic [7:0] cfg;
      logic [SW-1:0] s;
      r = $urandom % 4;
      s = SW'($urandom);
      cfg = {1'b0, 2'(r), 2'($urandom), 1'($urandom), 1'($urandom), 1'b0};
      adcSample = s;
      cfgWrite(cfg);
      check(cfgRdData == cfg, "R2 readback", cfgRdData, cfg);
      waitDone(8 * BASE + 4, n);
      check(n > 0, "R3 old window ends", n, 1);
      waitDone(8 * BASE + 4, n);
      check(n == periodOf(r), "R3 window length", n, periodOf(r));
      check(tempWord == expWord(s, r), "R4 masked result", tempWord, expWord(s, r));
      @(negedge clk);
      check(!convDone, "R5 single-cycle pulse", convDone, 0);
    end

    // R8: single-conversion request while running (res 1, SD=0).
    cfgWrite(8'b0_01_00_0_0_0);
    waitDone(8 * BASE + 4, n);
    waitDone(8 * BASE + 4, n);
    repeat (2) @(negedge clk);
    cfgWrite(8'b1_01_00_0_0_0);
    check(cfgRdData[7] == 1'b0, "R2 start bit reads 0", cfgRdData, 8'h20);
    waitDone(8 * BASE + 4, n);
    check(n + 4 == periodOf(1), "R8 request ignored while running", n + 4, periodOf(1));

    // R6: stop bit mid conversion.
    adcSample = 12'h7FF;
    repeat (3) @(negedge clk);
    cfgWrite(8'b0_11_00_0_0_1);
    waitDone(8 * BASE + 4, n);
    check(n + 5 == periodOf(1), "R6 current conversion completes", n + 5, periodOf(1));
    check(tempWord == expWord(12'h7FF, 1), "R6 final result delivered", tempWord, expWord(12'h7FF, 1));
    check(!convActive, "R6 idle after stop", convActive, 0);
    held = tempWord;
    adcSample = 12'h123;
    quietFor(3 * periodOf(3), seen);
    check(!seen, "R6 no pulses while idle", seen, 0);
    check(tempWord == held, "R6 word held while idle", tempWord, held);

    // R7: single conversion at 11 bits from idle.
    adcSample = 12'hC97;
    cfgWrite(8'b1_10_00_0_0_1);
    check(convActive, "R7 conversion started", convActive, 1);
    waitDone(8 * BASE + 4, n);
    check(n == periodOf(2), "R7 single window length", n, periodOf(2));
    check(tempWord == expWord(12'hC97, 2), "R7 single result", tempWord, expWord(12'hC97, 2));
    check(!convActive, "R7 back to idle", convActive, 0);
    quietFor(2 * periodOf(3), seen);
    check(!seen, "R7 exactly one pulse", seen, 0);

    // R9: resume continuous conversions at 12 bits.
    adcSample = 12'hFFC;
    cfgWrite(8'b0_11_00_0_0_0);
    check(convActive, "R9 resumed", convActive, 1);
    waitDone(8 * BASE + 4, n);
    check(n == periodOf(3), "R9 first window", n, periodOf(3));
    waitDone(8 * BASE + 4, n);
    check(n == periodOf(3), "R9 continues", n, periodOf(3));
    check(tempWord == expWord(12'hFFC, 3), "R4 12-bit keeps all bits", tempWord, expWord(12'hFFC, 3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule